// File: doc/BRIEF.md
# Energy-to-Frequency Pulse Converter

This block turns per-phase instantaneous power samples into an active-low pulse train on a frequency-output pin. A meter is calibrated by counting these pulses against a reference. It has several converters in parallel, three by default. Each converter picks one of four power types and any subset of the three phases. On every sample strobe it adds the signed sum of the chosen phase powers into an accumulator.

Conversion runs in two stages. In the first stage, each time the accumulated energy reaches a programmable threshold in either sign, one energy event is produced and the threshold is taken back out of the accumulator. In the second stage, a 16-bit divisor turns every N events into one output pulse. The low time of the pulse is a parameter in clock cycles. For fast pulse trains the low time is limited to half the time since the previous pulse. Each pin can also be given to an alternate signal, which then drives the pin in place of the pulses.

The phase mask and power-type select of each converter are held in the block. Reset loads their defaults, and a load strobe replaces them. The divisor, the threshold and the alternate-function controls are plain inputs.

Top module: `e2f_conv`

## Requirements
- R1: Phase mask bit 0 adds phase A, bit 1 adds phase B and bit 2 adds phase C to a converter's sum. A cleared bit leaves that phase out.
- R2: A converter whose phase mask is 000 never produces a pulse, whatever the inputs.
- R3: The select code picks the power type. 000 selects total active power (power slot 0), 010 selects apparent power (slot 1), 011 selects fundamental active power (slot 2) and 100 selects fundamental reactive power (slot 3). The reserved codes 001, 101, 110 and 111 act as a zero input and give no pulses.
- R4: After reset, every phase mask is 111. The select codes are 000 for converter 0, 100 for converter 1 and 010 for converter 2. A pulse on `cfg_ld_i` loads new masks and selects.
- R5: On each strobe, the signed sum is added to an accumulator that starts at zero after reset. When the accumulator reaches +threshold or more, or −threshold or less, one event is produced and the threshold is subtracted or added back. Negative energy therefore yields events too.
- R6: With divisor N ≥ 1, the converter emits one pulse for every N events. With N = 1, every event produces a pulse.
- R7: With divisor 0, the converter produces no pulses.
- R8: The pin idles high, including during and after reset. A pulse drives the pin low for `LOW_CYC` cycles when pulses are far apart.
- R9: The low time of a pulse is limited to half the number of cycles since the previous pulse started, and is never less than one cycle.
- R10: While a converter's alternate enable is set, its pin follows the alternate signal and no pulse reaches the pin.
- R11: A strobe that produces a pulse drives the pin low after the second rising clock edge at which the strobe is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_vld_i | input | 1 | Power sample strobe |
| pwr_i | input | N_TYPE*N_PH*PW | Signed power samples; slot t, phase p at bits [(t*3+p)*PW +: PW] |
| cfg_ld_i | input | 1 | Loads the phase masks and selects |
| phase_mask_i | input | N_CF*3 | Phase masks, 3 bits per converter |
| type_sel_i | input | N_CF*3 | Power-type selects, 3 bits per converter |
| divisor_i | input | N_CF*DIV_W | Event divisor per converter |
| threshold_i | input | ACC_W | Energy per event, shared by all converters |
| alt_en_i | input | N_CF | Gives each pin to its alternate signal |
| alt_sig_i | input | N_CF | Alternate signal per pin |
| pulse_o | output | N_CF | Frequency outputs, active low |

## Verification
The accumulator bound check assumes that the threshold is positive, that it stays fixed while samples arrive, and that it is at least as large as the magnitude of any single selected sum. This guarantees at most one event per strobe. The bench resets the block before each scenario and only then sets a new threshold. It keeps every per-sample sum at or below the threshold. Strobes are spaced far enough apart that pulses do not overlap, except in the scenario that deliberately exercises low-time clipping.

// File: rtl/e2f_pkg.sv
package e2f_pkg;
  localparam int N_PH   = 3;
  localparam int N_TYPE = 4;
  localparam int SEL_W  = 3;

  localparam logic [SEL_W-1:0] SEL_TOT_ACT    = 3'b000;
  localparam logic [SEL_W-1:0] SEL_APPARENT   = 3'b010;
  localparam logic [SEL_W-1:0] SEL_FUND_ACT   = 3'b011;
  localparam logic [SEL_W-1:0] SEL_FUND_REACT = 3'b100;

  typedef struct packed {
    logic       vld;
    logic [1:0] slot;
  } slot_t;

  function automatic slot_t sel_to_slot(logic [SEL_W-1:0] sel);
    slot_t s;
    s = '{vld: 1'b1, slot: 2'd0};
    case (sel)
      SEL_TOT_ACT:    s.slot = 2'd0;
      SEL_APPARENT:   s.slot = 2'd1;
      SEL_FUND_ACT:   s.slot = 2'd2;
      SEL_FUND_REACT: s.slot = 2'd3;
      default:        s.vld  = 1'b0;
    endcase
    return s;
  endfunction

  function automatic logic [SEL_W-1:0] dflt_sel(int idx);
    case (idx)
      1:       return SEL_FUND_REACT;
      2:       return SEL_APPARENT;
      default: return SEL_TOT_ACT;
    endcase
  endfunction
endpackage

// File: rtl/e2f_phase_sum.sv
module e2f_phase_sum
  import e2f_pkg::*;
#(
  parameter int PW    = 24,
  parameter int SUM_W = PW + 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_TYPE*N_PH*PW-1:0]      pwr_i,
  input  logic [N_PH-1:0]                mask_i,
  input  logic [SEL_W-1:0]               sel_i,
  output logic signed [SUM_W-1:0]        sum_o
);
  slot_t s;
  assign s = sel_to_slot(sel_i);

  always_comb begin
    sum_o = '0;
    for (int p = 0; p < N_PH; p++) begin
      if (s.vld && mask_i[p])
        sum_o = sum_o + SUM_W'($signed(pwr_i[(int'(s.slot)*N_PH+p)*PW +: PW]));
    end
  end

  p_mask_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |-> (sum_o == '0));
  p_reserved_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b001 || sel_i[2:1] == 2'b11 || sel_i == 3'b101) |-> (sum_o == '0));
endmodule

// File: rtl/e2f_accum.sv
module e2f_accum #(
  parameter int SUM_W = 26,
  parameter int ACC_W = 40
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sample_vld_i,
  input  logic signed [SUM_W-1:0] sum_i,
  input  logic [ACC_W-1:0]        thr_i,
  output logic                    evt_o
);
  logic signed [ACC_W-1:0] acc_q, acc_nx, acc_d, thr_s, sum_ext;
  logic evt_d;

  assign thr_s   = $signed(thr_i);
  assign sum_ext = ACC_W'(sum_i);
  assign acc_nx  = acc_q + sum_ext;

  always_comb begin
    acc_d = acc_nx;
    evt_d = 1'b0;
    if (acc_nx >= thr_s) begin
      acc_d = acc_nx - thr_s;
      evt_d = 1'b1;
    end else if (acc_nx <= -thr_s) begin
      acc_d = acc_nx + thr_s;
      evt_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      evt_o <= 1'b0;
    end else begin
      evt_o <= sample_vld_i & evt_d;
      if (sample_vld_i) acc_q <= acc_d;
    end
  end

  p_evt_on_sample_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> $past(sample_vld_i));
  p_acc_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sample_vld_i) && $stable(thr_i)) |-> (acc_q < thr_s && acc_q > -thr_s));
endmodule

// File: rtl/e2f_divider.sv
module e2f_divider #(
  parameter int DIV_W   = 16,
  parameter int LOW_CYC = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             low_o
);
  localparam int LW   = $clog2(LOW_CYC + 1);
  localparam int SC_W = $clog2(2 * LOW_CYC + 2);
  localparam logic [SC_W-1:0] SAT = SC_W'(2 * LOW_CYC + 1);

  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W:0]   cnt_nx;
  logic [SC_W-1:0]  since_q, half;
  logic [LW-1:0]    low_cnt, width_q, lim;
  logic             start;

  assign cnt_nx = {1'b0, div_cnt} + 1'b1;
  assign start  = evt_i && (divisor_i != '0) && (cnt_nx >= {1'b0, divisor_i});
  assign half   = since_q >> 1;

  // low time: half the last start-to-start gap, capped at LOW_CYC, at least 1
  always_comb begin
    if (half > SC_W'(LOW_CYC)) lim = LW'(LOW_CYC);
    else if (half == '0)       lim = LW'(1);
    else                       lim = LW'(half);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt <= '0;
      since_q <= SAT;
      low_cnt <= '0;
      width_q <= '0;
      low_o   <= 1'b0;
    end else begin
      if (evt_i && divisor_i != '0) div_cnt <= start ? '0 : cnt_nx[DIV_W-1:0];
      if (start) begin
        since_q <= SC_W'(1);
        width_q <= lim;
        low_cnt <= LW'(1);
        low_o   <= 1'b1;
      end else begin
        if (since_q != SAT) since_q <= since_q + 1'b1;
        if (low_o) begin
          if (low_cnt >= width_q) low_o <= 1'b0;
          else                    low_cnt <= low_cnt + 1'b1;
        end
      end
    end
  end

  p_start_after_evt_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(low_o) |-> $past(evt_i));
  p_width_max_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_o |-> (low_cnt <= LW'(LOW_CYC)));
  p_div0_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(divisor_i) == '0 && $past(!low_o)) |-> !low_o);
endmodule

// File: rtl/e2f_conv.sv
module e2f_conv
  import e2f_pkg::*;
#(
  parameter int N_CF    = 3,
  parameter int PW      = 24,
  parameter int ACC_W   = 40,
  parameter int DIV_W   = 16,
  parameter int LOW_CYC = 50
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         sample_vld_i,
  input  logic [N_TYPE*N_PH*PW-1:0]    pwr_i,
  input  logic                         cfg_ld_i,
  input  logic [N_CF*N_PH-1:0]         phase_mask_i,
  input  logic [N_CF*SEL_W-1:0]        type_sel_i,
  input  logic [N_CF*DIV_W-1:0]        divisor_i,
  input  logic [ACC_W-1:0]             threshold_i,
  input  logic [N_CF-1:0]              alt_en_i,
  input  logic [N_CF-1:0]              alt_sig_i,
  output logic [N_CF-1:0]              pulse_o
);
  localparam int SUM_W = PW + 2;

  for (genvar i = 0; i < N_CF; i++) begin : g_cf
    logic [N_PH-1:0]         mask_q;
    logic [SEL_W-1:0]        sel_q;
    logic signed [SUM_W-1:0] sum;
    logic                    evt, low;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q <= '1;
        sel_q  <= dflt_sel(i);
      end else if (cfg_ld_i) begin
        mask_q <= phase_mask_i[i*N_PH +: N_PH];
        sel_q  <= type_sel_i[i*SEL_W +: SEL_W];
      end
    end

    e2f_phase_sum #(.PW(PW), .SUM_W(SUM_W)) u_sum (
      .clk_i, .rst_ni, .pwr_i, .mask_i(mask_q), .sel_i(sel_q), .sum_o(sum));

    e2f_accum #(.SUM_W(SUM_W), .ACC_W(ACC_W)) u_acc (
      .clk_i, .rst_ni, .sample_vld_i, .sum_i(sum), .thr_i(threshold_i), .evt_o(evt));

    e2f_divider #(.DIV_W(DIV_W), .LOW_CYC(LOW_CYC)) u_div (
      .clk_i, .rst_ni, .evt_i(evt), .divisor_i(divisor_i[i*DIV_W +: DIV_W]), .low_o(low));

    assign pulse_o[i] = alt_en_i[i] ? alt_sig_i[i] : ~low;
  end
endmodule

// File: tb/tb_e2f_conv.sv
module tb_e2f_conv;
  localparam int N_CF = 3, PW = 24, ACC_W = 40, DIV_W = 16, LOW_CYC = 50;

  logic clk_i = 1'b0, rst_ni = 1'b0, sample_vld_i = 1'b0, cfg_ld_i = 1'b0;
  logic [4*3*PW-1:0]     pwr_i = '0;
  logic [N_CF*3-1:0]     phase_mask_i = '0, type_sel_i = '0;
  logic [N_CF*DIV_W-1:0] divisor_i = '0;
  logic [ACC_W-1:0]      threshold_i = ACC_W'(1000);
  logic [N_CF-1:0]       alt_en_i = '0, alt_sig_i = '0, pulse_o;

  e2f_conv #(.N_CF(N_CF), .PW(PW), .ACC_W(ACC_W), .DIV_W(DIV_W), .LOW_CYC(LOW_CYC)) dut (.*);

  always #10 clk_i = ~clk_i;  // 50 MHz

  int total = 0, bad = 0;
  int fall_cnt [N_CF], run_len [N_CF], last_w [N_CF];
  logic [N_CF-1:0] prev_pin = '1;

  typedef struct { string tag; int e [N_CF]; int base [N_CF]; } exp_t;
  exp_t sbq [$];

  initial for (int i = 0; i < N_CF; i++) begin fall_cnt[i] = 0; run_len[i] = 0; last_w[i] = 0; end

  // monitor: edge counts and low widths, sampled mid-cycle
  always @(negedge clk_i) begin
    for (int i = 0; i < N_CF; i++) begin
      if (prev_pin[i] && !pulse_o[i]) fall_cnt[i]++;
      if (!pulse_o[i]) run_len[i]++;
      else if (!prev_pin[i]) begin last_w[i] = run_len[i]; run_len[i] = 0; end
    end
    prev_pin = pulse_o;
  end

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic set_pwr(int t, int a, int b, int c);
    pwr_i[(t*3+0)*PW +: PW] = PW'(a);
    pwr_i[(t*3+1)*PW +: PW] = PW'(b);
    pwr_i[(t*3+2)*PW +: PW] = PW'(c);
  endtask

  task automatic set_div(int d0, int d1, int d2);
    divisor_i = {DIV_W'(d2), DIV_W'(d1), DIV_W'(d0)};
  endtask

  task automatic load_cfg(logic [2:0] m0, m1, m2, logic [2:0] s0, s1, s2);
    @(negedge clk_i);
    phase_mask_i = {m2, m1, m0};
    type_sel_i   = {s2, s1, s0};
    cfg_ld_i = 1'b1;
    @(negedge clk_i); cfg_ld_i = 1'b0;
  endtask

  task automatic run(int n, int gap);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i); sample_vld_i = 1'b1;
      @(negedge clk_i); sample_vld_i = 1'b0;
      repeat (gap - 2) @(negedge clk_i);
    end
    repeat (200) @(negedge clk_i);
  endtask

  // driver: push expectation, run stimulus, monitor side pops and compares
  task automatic window(string tag, int e0, e1, e2, int n);
    exp_t x;
    x.tag = tag; x.e[0] = e0; x.e[1] = e1; x.e[2] = e2;
    for (int i = 0; i < N_CF; i++) x.base[i] = fall_cnt[i];
    sbq.push_back(x);
    run(n, 120);
    x = sbq.pop_front();
    for (int i = 0; i < N_CF; i++)
      check($sformatf("%s cf%0d pulses", x.tag, i), fall_cnt[i] - x.base[i], x.e[i]);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk_i);
      wd++;
      if (wd > 150000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", wd);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    do_reset();
    check("R8 reset idle high", int'(pulse_o), 7);

    // R4 defaults (R3, R6 div 1): slot0=100/ph, slot1=200/ph, slot3=50/ph
    set_pwr(0, 100, 100, 100); set_pwr(1, 200, 200, 200);
    set_pwr(2, 0, 0, 0);       set_pwr(3, 50, 50, 50);
    set_div(1, 1, 1);
    window("R4_defaults", 6, 3, 12, 20);

    // R1/R2 masks
    do_reset();
    set_pwr(0, 100, 200, 300);
    load_cfg(3'b001, 3'b110, 3'b000, 3'b000, 3'b000, 3'b000);
    window("R1_R2_mask", 2, 10, 0, 20);

    // R3 fundamental active and reserved codes
    do_reset();
    set_pwr(2, 100, 100, 100);
    load_cfg(3'b111, 3'b111, 3'b111, 3'b011, 3'b001, 3'b111);
    window("R3_select", 6, 0, 0, 20);

    // R6 / R7 divisors 3, 0, 5; 12 events
    do_reset();
    set_pwr(0, 100, 100, 100);
    load_cfg(3'b111, 3'b111, 3'b111, 3'b000, 3'b000, 3'b000);
    set_div(3, 0, 5);
    window("R6_R7_divisor", 4, 0, 2, 40);

    // R5 signed energy
    do_reset();
    set_pwr(0, 200, -100, -100);
    load_cfg(3'b110, 3'b111, 3'b001, 3'b000, 3'b000, 3'b000);
    set_div(1, 1, 1);
    window("R5_signed", 8, 0, 8, 40);

    // R10 alternate function on cf1
    do_reset();
    set_pwr(0, 100, 100, 100); set_pwr(3, 50, 50, 50);
    alt_en_i = 3'b010; alt_sig_i = 3'b010;
    window("R10_alt", 6, 0, 12, 20);
    @(negedge clk_i); alt_sig_i = 3'b000;
    @(negedge clk_i);
    check("R10 pin follows alt", int'(pulse_o[1]), 0);
    alt_en_i = '0;
    @(negedge clk_i);
    check("R10 pin released idle", int'(pulse_o[1]), 1);

    // R11 latency, R8 width
    do_reset();
    set_pwr(0, 100, 100, 100); set_pwr(1, 0, 0, 0); set_pwr(3, 0, 0, 0);
    threshold_i = ACC_W'(300);
    set_div(1, 1, 1);
    @(negedge clk_i); sample_vld_i = 1'b1;
    @(negedge clk_i); sample_vld_i = 1'b0;
    check("R11 pin high after first edge", int'(pulse_o[0]), 1);
    @(negedge clk_i);
    check("R11 pin low after second edge", int'(pulse_o[0]), 0);
    repeat (120) @(negedge clk_i);
    check("R8 low width", last_w[0], LOW_CYC);

    // R9 clipping at 20-cycle pulse period
    do_reset();
    run(10, 20);
    check("R9 clipped width", last_w[0], 10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule